// File: doc/BRIEF.md
# Multi-Threshold Thermal Interrupt Monitor

This block watches a stream of already filtered 12-bit temperature readings and compares every reading from sensor channel 0 against five programmable limits: a hot limit, a normal-to-hot limit, a cold limit, an upper offset limit and a lower offset limit. Each crossing sets a sticky flag in a status register. Software clears a flag by writing a one to its bit. A single interrupt line is raised while any flag is set and enabled.

The hot comparison does not use one limit alone. It uses the larger of the hot limit and the normal-to-hot limit. A reading above that level sets two flags at once: the hot flag and the normal-to-hot flag. Until software has written the normal-to-hot limit, the cold limit stands in for it in that comparison. Readings from channels 1 to 3 are accepted on the input, but they set no flags. Each channel's enable bit is still stored and can be read back.

Register access uses one address for both directions. A write happens on the cycle `reg_wr` is high. Read data for the address presented on one cycle appears on `reg_rdata` after the next rising edge.

Top module: `thermo_alarm`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq` is low, and the normal-to-hot limit counts as unprogrammed.
- R2: The register map is: address 0 holds channel enables in bits 3:0; address 1 holds flag enables in bits 4:0; address 2 holds status; addresses 3 to 7 hold the hot, normal-to-hot, cold, upper offset and lower offset limits in bits 11:0. Bits that are not stored read as zero, and read data appears one cycle after the address.
- R3: An accepted reading strictly below the cold limit sets status bit 1. A reading equal to the limit does not.
- R4: An accepted reading strictly above the larger of the hot limit and the effective normal-to-hot limit sets status bit 0 (hot) and status bit 4 (normal-to-hot) together.
- R5: Until address 4 has been written, the cold limit is used as the effective normal-to-hot limit.
- R6: An accepted reading strictly above the upper offset limit sets status bit 2. One strictly below the lower offset limit sets status bit 3.
- R7: A reading is accepted only when it comes from channel 0 and channel-enable bit 0 is set. Any other reading leaves status unchanged.
- R8: Status flags are sticky and are set whether or not their flag enable is set.
- R9: Writing address 2 clears each status bit written as one. A flag raised by a reading in the same cycle stays set.
- R10: `irq` is high exactly one cycle after any status bit and its matching flag enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Reading present this cycle |
| smp_chan | input | 2 | Sensor channel of the reading |
| smp_data | input | 12 | Filtered reading |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, registered |

## Verification
A reading or a status write sampled at a rising edge changes the status register at that same edge. The status register's read value and `irq` each follow one edge later. A threshold write affects only readings sampled at later edges. The bench drives every input on the falling edge. Its behavioural model updates on the rising edge from the inputs it sees and from its own state before that edge, and it compares `reg_rdata` and `irq` at every falling edge. The directed checks read status through the register port one cycle after each reading. They sample `irq` one further cycle later, so every check falls on the cycle its result is due.

// File: rtl/thm_pkg.sv
package thm_pkg;
  // status / flag-enable bit positions (software decodes these)
  localparam int NFLAG  = 5;
  localparam int F_HOT  = 0;
  localparam int F_COLD = 1;
  localparam int F_HOFS = 2;
  localparam int F_LOFS = 3;
  localparam int F_HOT2 = 4;

  // threshold slots, in address order starting at A_THR0
  localparam int NTH    = 5;
  localparam int T_HOT  = 0;
  localparam int T_N2H  = 1;
  localparam int T_COLD = 2;
  localparam int T_HOFS = 3;
  localparam int T_LOFS = 4;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_IEN  = 1;
  localparam int A_STAT = 2;
  localparam int A_THR0 = 3;
endpackage

// File: rtl/thm_cmp.sv
module thm_cmp
  import thm_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0]          sample,
  input  logic [NTH-1:0][DW-1:0] thr,
  input  logic                   n2h_valid,
  output logic [NFLAG-1:0]       hits
);
  logic [DW-1:0] n2h_eff;
  logic [DW-1:0] hot_lim;
  logic          over_hot;

  always_comb begin
    // an unwritten normal-to-hot limit is replaced by the cold limit
    n2h_eff  = n2h_valid ? thr[T_N2H] : thr[T_COLD];
    hot_lim  = (thr[T_HOT] > n2h_eff) ? thr[T_HOT] : n2h_eff;
    over_hot = sample > hot_lim;

    hits         = '0;
    hits[F_HOT]  = over_hot;
    hits[F_HOT2] = over_hot;
    hits[F_COLD] = sample < thr[T_COLD];
    hits[F_HOFS] = sample > thr[T_HOFS];
    hits[F_LOFS] = sample < thr[T_LOFS];
  end
endmodule

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
#(
  parameter int DW    = 12,
  parameter int RW    = 32,
  parameter int AW    = 3,
  parameter int NSENS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [RW-1:0]          wdata,
  input  logic [NFLAG-1:0]       set_flags,
  output logic [RW-1:0]          rdata,
  output logic [NTH-1:0][DW-1:0] thr,
  output logic                   n2h_valid,
  output logic [NSENS-1:0]       sens_en,
  output logic [NFLAG-1:0]       irq_en,
  output logic [NFLAG-1:0]       status
);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(A_CTRL);
  localparam logic [AW-1:0] ADDR_IEN  = AW'(A_IEN);
  localparam logic [AW-1:0] ADDR_STAT = AW'(A_STAT);
  localparam logic [AW-1:0] ADDR_N2H  = AW'(A_THR0 + T_N2H);

  logic [NFLAG-1:0] clr;
  logic [RW-1:0]    rd_next;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[RW-1:DW];
  assign clr = (wr_en && addr == ADDR_STAT) ? wdata[NFLAG-1:0] : '0;

  // status: write-one-to-clear, a new hit wins
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr) | set_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_en   <= '0;
      irq_en    <= '0;
      n2h_valid <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_CTRL) sens_en <= wdata[NSENS-1:0];
      if (addr == ADDR_IEN)  irq_en  <= wdata[NFLAG-1:0];
      if (addr == ADDR_N2H)  n2h_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr <= '0;
    end else begin
      for (int i = 0; i < NTH; i++) begin
        if (wr_en && addr == AW'(A_THR0 + i)) thr[i] <= wdata[DW-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_CTRL) rd_next = RW'(sens_en);
    if (addr == ADDR_IEN)  rd_next = RW'(irq_en);
    if (addr == ADDR_STAT) rd_next = RW'(status);
    for (int i = 0; i < NTH; i++) begin
      if (addr == AW'(A_THR0 + i)) rd_next = RW'(thr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag_chk
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status[g] && !clr[g]) |=> status[g]);
    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !set_flags[g]) |=> !status[g]);
  end
endmodule

// File: rtl/thm_irq.sv
module thm_irq
  import thm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] status,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & irq_en);
  end

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status & irq_en)) |=> irq);
  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(status & irq_en)) |=> !irq);
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
  import thm_pkg::*;
#(
  parameter int DW    = 12,
  parameter int RW    = 32,
  parameter int AW    = 3,
  parameter int NSENS = 4,
  localparam int CW   = $clog2(NSENS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp_chan,
  input  logic [DW-1:0] smp_data,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq
);
  logic [NTH-1:0][DW-1:0] thr;
  logic                   n2h_valid;
  logic [NSENS-1:0]       sens_en;
  logic [NFLAG-1:0]       irq_en;
  logic [NFLAG-1:0]       status;
  logic [NFLAG-1:0]       hits;
  logic [NFLAG-1:0]       set_flags;
  logic                   accept;

  assign accept    = smp_valid && (smp_chan == '0) && sens_en[0];
  assign set_flags = accept ? hits : '0;

  thm_cmp #(.DW(DW)) u_cmp (
    .sample    (smp_data),
    .thr       (thr),
    .n2h_valid (n2h_valid),
    .hits      (hits)
  );

  thm_regs #(.DW(DW), .RW(RW), .AW(AW), .NSENS(NSENS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .set_flags (set_flags),
    .rdata     (reg_rdata),
    .thr       (thr),
    .n2h_valid (n2h_valid),
    .sens_en   (sens_en),
    .irq_en    (irq_en),
    .status    (status)
  );

  thm_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .irq_en (irq_en),
    .irq    (irq)
  );

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !(reg_wr && reg_addr == AW'(A_STAT))) |=> $stable(status));
  // R3
  cold_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && smp_data < thr[T_COLD]) |=> status[F_COLD]);
  // R4
  hot_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[F_HOT]) |-> status[F_HOT2]);
endmodule

// File: tb/thermo_alarm_bench.sv
module thermo_alarm_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermo_alarm u_thermo_alarm (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_ien, m_stat, m_rdata;
  logic [31:0] m_thr [5];
  bit          m_n2hv, m_irq;

  always @(posedge clk) begin
    logic [31:0] rd, setv, clrv;
    int lim, n2h, d;
    if (rst) begin
      m_ctrl = 0; m_ien = 0; m_stat = 0; m_rdata = 0; m_n2hv = 0; m_irq = 0;
      foreach (m_thr[i]) m_thr[i] = 0;
    end else begin
      case (reg_addr)
        3'd0: rd = m_ctrl;
        3'd1: rd = m_ien;
        3'd2: rd = m_stat;
        default: rd = m_thr[int'(reg_addr) - 3];
      endcase
      setv = 0;
      if (smp_valid && smp_chan == 0 && m_ctrl[0]) begin
        d   = int'(smp_data);
        n2h = m_n2hv ? int'(m_thr[1]) : int'(m_thr[2]);
        lim = (int'(m_thr[0]) > n2h) ? int'(m_thr[0]) : n2h;
        if (d > lim)              setv = setv | 32'h11;
        if (d < int'(m_thr[2]))   setv = setv | 32'h02;
        if (d > int'(m_thr[3]))   setv = setv | 32'h04;
        if (d < int'(m_thr[4]))   setv = setv | 32'h08;
      end
      clrv  = (reg_wr && reg_addr == 3'd2) ? (reg_wdata & 32'h1F) : 0;
      m_irq = (m_stat & m_ien) != 0;
      m_stat = (m_stat & ~clrv) | setv;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_ctrl = reg_wdata & 32'hF;
          3'd1: m_ien  = reg_wdata & 32'h1F;
          3'd2: ;
          default: begin
            m_thr[int'(reg_addr) - 3] = reg_wdata & 32'hFFF;
            if (reg_addr == 3'd4) m_n2hv = 1;
          end
        endcase
      end
      m_rdata = rd;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model rdata", reg_rdata, m_rdata);
      chk("R10 model irq", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic smp(input logic [1:0] c, input logic [11:0] d);
    @(negedge clk); smp_valid = 1; smp_chan = c; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic stat_is(string tag, logic [31:0] exp);
    logic [31:0] v;
    rd(3'd2, v);
    chk(tag, v, exp);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 reset irq", {31'b0, irq}, 0);

    wr(3'd0, 32'h1);
    wr(3'd3, 32'h800); wr(3'd5, 32'h100); wr(3'd6, 32'h900); wr(3'd7, 32'h080);
    rd(3'd0, v); chk("R2 ctrl readback", v, 32'h1);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk("R2 limit width", v, 32'hFFF);
    wr(3'd3, 32'h800);

    smp(0, 12'h400); stat_is("R3 mid reading", 0);
    smp(0, 12'h100); stat_is("R3 equal cold", 0);
    smp(0, 12'h0FF); stat_is("R3 below cold", 32'h02);
    chk("R8 disabled flag no irq", {31'b0, irq}, 0);
    smp(0, 12'h400); stat_is("R8 sticky", 32'h02);
    wr(3'd2, 32'h2); stat_is("R9 clear", 0);

    smp(0, 12'h801); stat_is("R4 above hot", 32'h11);
    wr(3'd2, 32'h1F);
    smp(0, 12'h800); stat_is("R4 equal hot", 0);

    wr(3'd3, 32'h050);
    smp(0, 12'h0A0); stat_is("R5 cold stands in", 32'h02);
    wr(3'd2, 32'h1F);
    smp(0, 12'h101); stat_is("R5 above fallback", 32'h11);
    wr(3'd2, 32'h1F);
    wr(3'd4, 32'h040);
    smp(0, 12'h0A0); stat_is("R5 programmed n2h", 32'h13);
    wr(3'd2, 32'h1F);
    wr(3'd4, 32'hA00);
    smp(0, 12'h901); stat_is("R6 upper offset", 32'h04);
    wr(3'd2, 32'h1F);
    smp(0, 12'h07F); stat_is("R6 lower offset", 32'h0A);
    wr(3'd2, 32'h1F);

    wr(3'd0, 32'hE); rd(3'd0, v); chk("R7 ctrl readback", v, 32'hE);
    smp(0, 12'h001); stat_is("R7 channel disabled", 0);
    wr(3'd0, 32'h1);
    smp(2, 12'h001); stat_is("R7 other channel", 0);

    smp(0, 12'h001); stat_is("R6 cold and lower", 32'h0A);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R2 enable width", v, 32'h1F);
    chk("R10 irq on", {31'b0, irq}, 1);
    wr(3'd1, 32'h04); @(negedge clk);
    chk("R10 masked", {31'b0, irq}, 0);
    wr(3'd1, 32'h08); @(negedge clk);
    chk("R10 enabled bit", {31'b0, irq}, 1);

    // R9 set wins over clear in same cycle
    @(negedge clk);
    smp_valid = 1; smp_chan = 0; smp_data = 12'h001;
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h0A;
    @(negedge clk); smp_valid = 0; reg_wr = 0;
    stat_is("R9 set wins", 32'h0A);
    wr(3'd2, 32'h02); stat_is("R9 partial clear", 32'h08);
    wr(3'd2, 32'h1F); stat_is("R9 full clear", 0);
    @(negedge clk);
    chk("R10 irq off", {31'b0, irq}, 0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule